// File: doc/BRIEF.md
# Read Request Tag and Completion Tracker

This block sits beside a bus-mastering DMA engine and looks after the bookkeeping of its outstanding memory reads. Each read the engine wants to issue is handed a tag, the lowest-numbered one not in use, and the tracker records how many bytes that read asked for. When every tag is in use, the engine is held off until one comes back.

Completions come back carrying a tag and a byte count. A large read may be answered in several pieces, because a responder splits data at 64-byte boundaries. Pieces for different reads may also arrive interleaved in any order. The tracker subtracts each piece from the bytes still owed on its tag. When nothing is owed, it frees the tag and reports it on a one-cycle done output. A completion for a tag that is not in use is flagged as unexpected and otherwise ignored.

Every tag in use also runs a timer that counts prescaled ticks. A read that is still unsatisfied after the configured number of ticks is reported as timed out, and its tag is released.

Top module: `tagtrk_top`

## Requirements
- R1: After reset every tag is free, `req_ready` is 1, `req_tag` is 0 and `done_valid`, `timeout_valid` and `unexp_err` are 0.
- R2: `req_tag` always shows the lowest-numbered free tag. A cycle with `req_valid` and `req_ready` both high allocates that tag and records `req_len` as the bytes it is owed.
- R3: `req_ready` is low exactly when all NUM_TAGS tags are in use. A `req_valid` while `req_ready` is low allocates nothing, so the next tag to be freed is the next one handed out.
- R4: A completion on an allocated tag subtracts `cpl_bytes` from the bytes it is owed. When `cpl_bytes` is at least the amount still owed, the tag is freed, and in the next cycle `done_valid` is 1 for one cycle with `done_tag` equal to that tag.
- R5: A request answered in several pieces produces no done report until the piece that clears the last owed byte.
- R6: Completions for different tags may arrive interleaved and in any order relative to issue. Each tag's done report follows its own final piece.
- R7: A completion whose tag is not allocated makes `unexp_err` 1 for exactly the next cycle. It changes no tag state and produces no done report.
- R8: Each allocated tag counts ticks of PRESCALE clock cycles from its allocation. Partial completions do not restart the count. After TIMEOUT_TICKS ticks without full satisfaction, `timeout_valid` is 1 for one cycle with `timeout_tag` naming the tag, and the tag is freed. A later completion on it counts as unexpected.
- R9: At most one timeout is reported per cycle. When several tags have expired, the lowest-numbered goes first and the rest follow in later cycles. A tag that receives a completion in a cycle is not reported as timed out in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Engine wants to issue a read |
| req_len | input | LEN_W | Byte count of that read |
| req_ready | output | 1 | A tag is free |
| req_tag | output | TAG_W | Tag the read will carry |
| cpl_valid | input | 1 | A completion piece arrives |
| cpl_tag | input | TAG_W | Tag of the completion |
| cpl_bytes | input | LEN_W | Bytes carried by the completion |
| done_valid | output | 1 | A request finished normally |
| done_tag | output | TAG_W | Tag of the finished request |
| timeout_valid | output | 1 | A request timed out |
| timeout_tag | output | TAG_W | Tag of the timed-out request |
| unexp_err | output | 1 | Completion on a tag not in use |

## Verification
The bench builds the tracker with NUM_TAGS=4, PRESCALE=4 and TIMEOUT_TICKS=8. Four tags let a few issues fill the table, so the stall and the reuse of a freed tag can be checked quickly. A short tick and a small limit make a timeout happen about thirty cycles after allocation. With four staggered requests expiring close together, the lowest-first ordering of timeout reports is exercised, and late completions on released tags can be shown to be rejected.

// File: rtl/tagtrk_pkg.sv
package tagtrk_pkg;
    localparam int TAGS_DEFAULT     = 32;
    localparam int LEN_W_DEFAULT    = 13;
    localparam int PRESCALE_DEFAULT = 256;
    localparam int TICKS_DEFAULT    = 1000;
endpackage

// File: rtl/tagtrk_lowest.sv
module tagtrk_lowest #(
    parameter int N = 32,
    parameter int W = 5
) (
    input  logic [N-1:0] mask,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = |mask;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/tagtrk_tick.sv
module tagtrk_tick #(
    parameter int PRESCALE = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(PRESCALE);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                tick  = (cnt_q == CW'(PRESCALE - 1));
                cnt_d = tick ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate
endmodule

// File: rtl/tagtrk_top.sv
module tagtrk_top #(
    parameter int NUM_TAGS      = tagtrk_pkg::TAGS_DEFAULT,
    parameter int LEN_W         = tagtrk_pkg::LEN_W_DEFAULT,
    parameter int PRESCALE      = tagtrk_pkg::PRESCALE_DEFAULT,
    parameter int TIMEOUT_TICKS = tagtrk_pkg::TICKS_DEFAULT,
    parameter int TAG_W         = $clog2(NUM_TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    output logic [TAG_W-1:0] req_tag,
    input  logic             cpl_valid,
    input  logic [TAG_W-1:0] cpl_tag,
    input  logic [LEN_W-1:0] cpl_bytes,
    output logic             done_valid,
    output logic [TAG_W-1:0] done_tag,
    output logic             timeout_valid,
    output logic [TAG_W-1:0] timeout_tag,
    output logic             unexp_err
);
    localparam int TMR_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [TMR_W-1:0] TMR_LIMIT = TMR_W'(TIMEOUT_TICKS);

    typedef struct packed {
        logic [NUM_TAGS-1:0]            busy;
        logic [NUM_TAGS-1:0][LEN_W-1:0] rem;
        logic [NUM_TAGS-1:0][TMR_W-1:0] tmr;
        logic                           done_v;
        logic [TAG_W-1:0]               done_t;
        logic                           to_v;
        logic [TAG_W-1:0]               to_t;
        logic                           unexp;
    } state_t;

    state_t s_d, s_q;

    logic                tick;
    logic                free_found;
    logic [TAG_W-1:0]    free_idx;
    logic [NUM_TAGS-1:0] exp_mask;
    logic                exp_found;
    logic [TAG_W-1:0]    exp_idx;
    logic                cpl_hit;

    tagtrk_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tagtrk_lowest #(.N(NUM_TAGS), .W(TAG_W)) u_free (
        .mask  (~s_q.busy),
        .found (free_found),
        .idx   (free_idx)
    );

    // expired tags, minus one being served by a completion this cycle
    always_comb begin
        cpl_hit = cpl_valid && s_q.busy[cpl_tag];
        for (int i = 0; i < NUM_TAGS; i++) begin
            exp_mask[i] = s_q.busy[i] && (s_q.tmr[i] == TMR_LIMIT)
                          && !(cpl_hit && (cpl_tag == TAG_W'(i)));
        end
    end

    tagtrk_lowest #(.N(NUM_TAGS), .W(TAG_W)) u_exp (
        .mask  (exp_mask),
        .found (exp_found),
        .idx   (exp_idx)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done_v = 1'b0;
        s_d.to_v   = 1'b0;
        s_d.unexp  = 1'b0;

        // per-tag tick counters, saturating at the limit
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (tick && s_q.busy[i] && (s_q.tmr[i] != TMR_LIMIT))
                s_d.tmr[i] = s_q.tmr[i] + 1'b1;
        end

        // completion matching
        if (cpl_valid) begin
            if (!s_q.busy[cpl_tag]) begin
                s_d.unexp = 1'b1;
            end else if (cpl_bytes >= s_q.rem[cpl_tag]) begin
                s_d.busy[cpl_tag] = 1'b0;
                s_d.rem[cpl_tag]  = '0;
                s_d.done_v        = 1'b1;
                s_d.done_t        = cpl_tag;
            end else begin
                s_d.rem[cpl_tag] = s_q.rem[cpl_tag] - cpl_bytes;
            end
        end

        // one timeout retired per cycle
        if (exp_found) begin
            s_d.busy[exp_idx] = 1'b0;
            s_d.to_v          = 1'b1;
            s_d.to_t          = exp_idx;
        end

        // allocation uses only tags free in the registered state
        if (req_valid && free_found) begin
            s_d.busy[free_idx] = 1'b1;
            s_d.rem[free_idx]  = req_len;
            s_d.tmr[free_idx]  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready     = free_found;
    assign req_tag       = free_idx;
    assign done_valid    = s_q.done_v;
    assign done_tag      = s_q.done_t;
    assign timeout_valid = s_q.to_v;
    assign timeout_tag   = s_q.to_t;
    assign unexp_err     = s_q.unexp;
endmodule

// File: rtl/tagtrk_checker.sv
module tagtrk_checker #(
    parameter int NUM_TAGS = 32,
    parameter int TAG_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             cpl_valid,
    input logic [TAG_W-1:0] cpl_tag,
    input logic             done_valid,
    input logic [TAG_W-1:0] done_tag,
    input logic             timeout_valid,
    input logic [TAG_W-1:0] timeout_tag,
    input logic             unexp_err
);
    localparam int CW = $clog2(NUM_TAGS + 1) + 1;

    // outstanding count rebuilt from handshakes and reports
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CW'(req_valid && req_ready)
                             - CW'(done_valid) - CW'(timeout_valid);
    end

    a_r3_ready_vs_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready == ((int'(cnt_q) - int'(done_valid) - int'(timeout_valid)) < NUM_TAGS));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= NUM_TAGS);

    a_r4_done_follows_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> ($past(cpl_valid) && ($past(cpl_tag) == done_tag)));

    a_r4_single_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !(done_valid && (done_tag == $past(done_tag))));

    a_r7_unexp_follows_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        unexp_err |-> ($past(cpl_valid) && !done_valid));

    a_r9_distinct_reports: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && timeout_valid) |-> (done_tag != timeout_tag));
endmodule

bind tagtrk_top tagtrk_checker #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .cpl_valid     (cpl_valid),
    .cpl_tag       (cpl_tag),
    .done_valid    (done_valid),
    .done_tag      (done_tag),
    .timeout_valid (timeout_valid),
    .timeout_tag   (timeout_tag),
    .unexp_err     (unexp_err)
);

// File: tb/tagtrk_top_test.sv
module tagtrk_top_test;
    localparam int N  = 4;
    localparam int LW = 13;
    localparam int P  = 4;
    localparam int L  = 8;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic          req_ready;
    logic [TW-1:0] req_tag;
    logic          cpl_valid = 1'b0;
    logic [TW-1:0] cpl_tag = '0;
    logic [LW-1:0] cpl_bytes = '0;
    logic          done_valid;
    logic [TW-1:0] done_tag;
    logic          timeout_valid;
    logic [TW-1:0] timeout_tag;
    logic          unexp_err;

    tagtrk_top #(.NUM_TAGS(N), .LEN_W(LW), .PRESCALE(P), .TIMEOUT_TICKS(L)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_len(req_len), .req_ready(req_ready), .req_tag(req_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_bytes(cpl_bytes),
        .done_valid(done_valid), .done_tag(done_tag),
        .timeout_valid(timeout_valid), .timeout_tag(timeout_tag),
        .unexp_err(unexp_err)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int n_run = 0, n_fail = 0;
    int q_done[$];
    int q_to_tag[$];
    int q_to_cyc[$];
    int q_unexp = 0;
    logic [N-1:0] bb = '0;
    int m_tag, m_cyc, m_el;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lowest_free(input logic [N-1:0] busy);
        for (int i = 0; i < N; i++) if (!busy[i]) return i;
        return -1;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_valid) begin
                if (q_done.size() == 0) check(1'b0, "R4 done with none expected", done_tag, -1);
                else begin
                    m_tag = q_done.pop_front();
                    check(done_tag == TW'(m_tag), "R4/R6 done tag", done_tag, m_tag);
                end
            end
            if (unexp_err) begin
                check(q_unexp > 0, "R7 unexp_err pulse", 1, 0);
                if (q_unexp > 0) q_unexp--;
            end
            if (timeout_valid) begin
                if (q_to_tag.size() == 0) check(1'b0, "R8 timeout with none expected", timeout_tag, -1);
                else begin
                    m_tag = q_to_tag.pop_front();
                    m_cyc = q_to_cyc.pop_front();
                    m_el  = cyc - m_cyc;
                    check(timeout_tag == TW'(m_tag), "R9 timeout order", timeout_tag, m_tag);
                    check(m_el >= (L - 1) * P && m_el <= L * P + N + 3,
                          "R8 timeout latency", m_el, L * P);
                    bb[timeout_tag] = 1'b0;
                end
            end
        end
    end

    task automatic issue(input int len, input bit expect_to);
        int exp_t;
        exp_t = lowest_free(bb);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_len   = LW'(len);
        check(req_ready == 1'b1, "R3 ready with free tag", req_ready, 1);
        check(req_tag == TW'(exp_t), "R2 lowest free tag", req_tag, exp_t);
        bb[exp_t] = 1'b1;
        if (expect_to) begin
            q_to_tag.push_back(exp_t);
            q_to_cyc.push_back(cyc);
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic cpl(input int tag, input int bytes, input bit last, input bit unexp);
        @(posedge clk); #1;
        cpl_valid = 1'b1;
        cpl_tag   = TW'(tag);
        cpl_bytes = LW'(bytes);
        if (last)  q_done.push_back(tag);
        if (unexp) q_unexp++;
        @(posedge clk); #1;
        cpl_valid = 1'b0;
        if (last) bb[tag] = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(req_tag == '0, "R1 tag after reset", req_tag, 0);
        check(!done_valid && !timeout_valid && !unexp_err, "R1 no events after reset",
              int'(done_valid) + int'(timeout_valid) + int'(unexp_err), 0);

        // R2 allocation, R5 split pieces, R6 out-of-order return
        issue(256, 0);
        issue(64, 0);
        issue(128, 0);
        cpl(1, 64, 1, 0);
        cpl(2, 64, 0, 0);
        cpl(0, 64, 0, 0);
        cpl(2, 64, 1, 0);
        cpl(0, 64, 0, 0);
        cpl(0, 64, 0, 0);
        cpl(0, 64, 1, 0);
        repeat (2) @(posedge clk);
        check(q_done.size() == 0, "R5 all split requests reported", q_done.size(), 0);

        // R3 full table stalls; stalled valid allocates nothing
        for (int i = 0; i < N; i++) issue(64, 0);
        @(posedge clk); #1;
        check(req_ready == 1'b0, "R3 ready low when full", req_ready, 0);
        req_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1 req_valid = 1'b0;
        cpl(2, 64, 1, 0);
        issue(64, 0);
        #1;
        check(req_ready == 1'b0, "R3 full again after one reuse", req_ready, 0);
        for (int i = 0; i < N; i++) cpl(i, 100, 1, 0);

        // R7 completion on a free tag
        cpl(3, 64, 0, 1);
        @(posedge clk); #1;
        check(req_ready == 1'b1 && req_tag == '0, "R7 state unchanged", req_tag, 0);
        check(q_unexp == 0, "R7 pulse observed", q_unexp, 0);

        // R8/R9 timeouts, partial completion does not restart the timer
        for (int i = 0; i < N; i++) issue(128, 1);
        cpl(0, 64, 0, 0);
        repeat (45) @(posedge clk);
        #1;
        check(q_to_tag.size() == 0, "R8 all timeouts reported", q_to_tag.size(), 0);
        check(req_ready == 1'b1 && req_tag == '0, "R8 timed-out tags freed", req_tag, 0);
        cpl(1, 64, 0, 1);
        @(posedge clk); #1;
        check(q_unexp == 0, "R8 late completion is unexpected", q_unexp, 0);
        check(q_done.size() == 0, "R4 no outstanding done", q_done.size(), 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule